// File: doc/BRIEF.md
# ASID-Tagged Direct-Mapped Translation Cache

This block keeps recently used three-level (39-bit virtual address) leaf translations so that most memory accesses avoid a page walk. Each slot holds one translation. The slot is chosen by the low bits of the virtual page number (VPN). A slot records:

- the full VPN,
- the address-space identifier (ASID) the walker used,
- a global flag,
- the physical page number (PPN),
- six permission bits,
- the page level (4 KiB, 2 MiB or 1 GiB).

A lookup is purely combinational. The caller presents a VPN and the current ASID, and in the same cycle receives a hit flag, the PPN, the permission bits and the level. For a superpage hit, the PPN low bits come from the request.

The page walker writes translations through a fill port. A fill overwrites its slot without any condition. A fence port invalidates entries following the usual supervisor fence rules: the address and the ASID are each optional, and global entries are kept by any fence that names an ASID. A fence takes one clock edge, and a lookup in the next cycle already sees its effect.

Top module: `asid_tlb`

## Requirements
- R1: After reset, every slot is invalid and every lookup misses.
- R2: A fill writes slot VPN[5:0] and sets it valid, replacing whatever that slot held. A lookup in the following cycle sees the new content.
- R3: A lookup hits only when all three hold:
  - the slot at VPN[5:0] is valid;
  - the stored VPN equals the request VPN on all bits the page level does not cover;
  - the stored ASID equals the request ASID.

  A hit returns the stored permission bits (bit 0 read, 1 write, 2 execute, 3 user, 4 accessed, 5 dirty) and the stored level.
- R4: A slot filled with the global flag set hits for any request ASID.
- R5: On a miss, the PPN, permission and level outputs are all zero.
- R6: Level encodes page size: 0 is 4 KiB, 1 is 2 MiB, 2 (and 3) is 1 GiB.
  - Level 1 leaves VPN[8:0] out of the match. Level 2 leaves VPN[17:0] out of the match.
  - The returned PPN takes those same low bits from the request VPN.
- R7: A fence with neither an address nor an ASID invalidates every slot.
- R8: A fence with only an address invalidates every slot that translates that address, under any ASID and including global slots. This covers superpages that hold the address in any slot.
- R9: A fence with only an ASID invalidates every non-global slot holding that ASID, and no other slot.
- R10: A fence with both an address and an ASID invalidates only non-global slots that match both.
- R11: A fence completes at a single clock edge. A lookup in the next cycle misses on every invalidated slot, and slots the fence did not select keep their contents.
- R12: A fill presented in the same cycle as a fence is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_vpn_i | input | 27 | Lookup virtual page number |
| lk_asid_i | input | 16 | Lookup address-space identifier |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ppn_o | output | 44 | Physical page number on hit, zero on miss |
| lk_perm_o | output | 6 | Permission bits on hit, zero on miss |
| lk_level_o | output | 2 | Page level on hit, zero on miss |
| wr_en_i | input | 1 | Fill strobe |
| wr_vpn_i | input | 27 | Fill virtual page number |
| wr_asid_i | input | 16 | Fill ASID |
| wr_glob_i | input | 1 | Fill global flag |
| wr_ppn_i | input | 44 | Fill physical page number |
| wr_perm_i | input | 6 | Fill permission bits |
| wr_level_i | input | 2 | Fill page level |
| sf_en_i | input | 1 | Fence strobe |
| sf_use_addr_i | input | 1 | Fence restricted to an address |
| sf_vpn_i | input | 27 | Fence virtual page number |
| sf_use_asid_i | input | 1 | Fence restricted to an ASID |
| sf_asid_i | input | 16 | Fence ASID |

## Verification
The bench builds the block with its default of 64 slots and the package widths. It draws VPNs from a small pool, which forces the following cases often:

- index collisions and evictions;
- superpage entries that alias several request VPNs;
- fences that hit global and non-global slots side by side.

With only three ASIDs and a mixed level distribution, all four fence operand combinations meet live matching entries. The random phase also regularly places a fill and a fence in the same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int unsigned VPN_W    = 27;
  localparam int unsigned PPN_W    = 44;
  localparam int unsigned ASID_W   = 16;
  localparam int unsigned PERM_W   = 6;
  localparam int unsigned LVL_W    = 2;
  localparam int unsigned LVL_BITS = 9;
  localparam int unsigned PAD_W    = PPN_W - VPN_W;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PPN_W-1:0]  ppn;
    logic [PERM_W-1:0] perm;
    logic [LVL_W-1:0]  level;
  } tlb_entry_t;

  // Bits of the VPN that take part in a match for a given page level.
  function automatic logic [VPN_W-1:0] lvl_mask(input logic [LVL_W-1:0] lvl);
    logic [VPN_W-1:0] m;
    m = '1;
    if (lvl != '0)          m[LVL_BITS-1:0]   = '0;
    if (lvl >= LVL_W'(2))   m[2*LVL_BITS-1:0] = '0;
    return m;
  endfunction

endpackage

// File: rtl/tlb_flush_sel.sv
module tlb_flush_sel
  import tlb_pkg::*;
(
  input  logic              valid_i,
  input  tlb_entry_t        ent_i,
  input  logic              use_addr_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic              use_asid_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              kill_o
);

  logic addr_hit;
  logic asid_hit;

  always_comb begin
    addr_hit = (((ent_i.vpn ^ vpn_i) & lvl_mask(ent_i.level)) == '0);
    asid_hit = !ent_i.glob && (ent_i.asid == asid_i);
    kill_o   = valid_i
             && (!use_addr_i || addr_hit)
             && (!use_asid_i || asid_hit);
  end

  always_comb begin
    if (use_asid_i && ent_i.glob)
      AST_GLOBAL_KEPT_BY_ASID_FENCE: assert (!kill_o); // R9
    if (!valid_i)
      AST_KILL_ONLY_VALID: assert (!kill_o); // R11
  end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  tlb_entry_t         ents_i [ENTRIES],
  input  logic [VPN_W-1:0]   vpn_i,
  input  logic [ASID_W-1:0]  asid_i,
  output logic               hit_o,
  output logic [PPN_W-1:0]   ppn_o,
  output logic [PERM_W-1:0]  perm_o,
  output logic [LVL_W-1:0]   level_o
);

  logic [IDX_W-1:0] idx;
  tlb_entry_t       sel;
  logic             sel_v;
  logic [VPN_W-1:0] vmask;
  logic [PPN_W-1:0] pmask;
  logic             tag_ok;
  logic             asid_ok;

  always_comb begin
    idx     = vpn_i[IDX_W-1:0];
    sel     = ents_i[idx];
    sel_v   = valid_i[idx];
    vmask   = lvl_mask(sel.level);
    pmask   = {{PAD_W{1'b1}}, vmask};
    tag_ok  = (((sel.vpn ^ vpn_i) & vmask) == '0);
    asid_ok = sel.glob || (sel.asid == asid_i);
    hit_o   = sel_v && tag_ok && asid_ok;
    if (hit_o) begin
      ppn_o   = (sel.ppn & pmask) | ({{PAD_W{1'b0}}, vpn_i} & ~pmask);
      perm_o  = sel.perm;
      level_o = sel.level;
    end else begin
      ppn_o   = '0;
      perm_o  = '0;
      level_o = '0;
    end
  end

  always_comb begin
    if (!hit_o)
      AST_MISS_OUTPUTS_ZERO: assert (ppn_o == '0 && perm_o == '0 && level_o == '0); // R5
    if (hit_o)
      AST_HIT_NEEDS_VALID: assert (valid_i[vpn_i[IDX_W-1:0]]); // R3
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_hit_o,
  output logic [PPN_W-1:0]  lk_ppn_o,
  output logic [PERM_W-1:0] lk_perm_o,
  output logic [LVL_W-1:0]  lk_level_o,
  input  logic              wr_en_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_glob_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic [PERM_W-1:0] wr_perm_i,
  input  logic [LVL_W-1:0]  wr_level_i,
  input  logic              sf_en_i,
  input  logic              sf_use_addr_i,
  input  logic [VPN_W-1:0]  sf_vpn_i,
  input  logic              sf_use_asid_i,
  input  logic [ASID_W-1:0] sf_asid_i
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // Storage
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [ENTRIES-1:0] wr_sel;
  logic [ENTRIES-1:0] kill;
  tlb_entry_t         ent_q [ENTRIES];
  tlb_entry_t         wr_ent;
  logic [IDX_W-1:0]   wr_idx;

  always_comb begin
    wr_ent.vpn   = wr_vpn_i;
    wr_ent.asid  = wr_asid_i;
    wr_ent.glob  = wr_glob_i;
    wr_ent.ppn   = wr_ppn_i;
    wr_ent.perm  = wr_perm_i;
    wr_ent.level = wr_level_i;
    wr_idx       = wr_vpn_i[IDX_W-1:0];
  end

  // Per-slot fence selection
  for (genvar k = 0; k < ENTRIES; k++) begin : g_fence
    tlb_flush_sel u_sel (
      .valid_i    (valid_q[k]),
      .ent_i      (ent_q[k]),
      .use_addr_i (sf_use_addr_i),
      .vpn_i      (sf_vpn_i),
      .use_asid_i (sf_use_asid_i),
      .asid_i     (sf_asid_i),
      .kill_o     (kill[k])
    );
  end

  // Next state: a fence has priority and drops a concurrent fill.
  always_comb begin
    valid_d = valid_q;
    wr_sel  = '0;
    if (sf_en_i) begin
      valid_d = valid_q & ~kill;
    end else if (wr_en_i) begin
      valid_d[wr_idx] = 1'b1;
      wr_sel[wr_idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= '0;
    else             valid_q <= valid_d;
  end

  for (genvar k = 0; k < ENTRIES; k++) begin : g_data
    always_ff @(posedge clk) begin
      if (wr_sel[k]) ent_q[k] <= wr_ent;
    end
  end

  tlb_lookup #(.ENTRIES(ENTRIES)) u_lookup (
    .valid_i (valid_q),
    .ents_i  (ent_q),
    .vpn_i   (lk_vpn_i),
    .asid_i  (lk_asid_i),
    .hit_o   (lk_hit_o),
    .ppn_o   (lk_ppn_o),
    .perm_o  (lk_perm_o),
    .level_o (lk_level_o)
  );

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> valid_q == '0); // R1
  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && !sf_en_i) |=> valid_q[$past(wr_vpn_i[IDX_W-1:0])]); // R2
  AST_FENCE_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sf_en_i && !sf_use_addr_i && !sf_use_asid_i) |=> valid_q == '0); // R7
  AST_FENCE_DROPS_FILL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sf_en_i |=> (valid_q & ~$past(valid_q)) == '0); // R12
  AST_ONLY_FENCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sf_en_i |=> ($past(valid_q) & ~valid_q) == '0); // R11

endmodule

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;
  import tlb_pkg::*;

  localparam int unsigned N = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [VPN_W-1:0]  lk_vpn;
  logic [ASID_W-1:0] lk_asid;
  logic              lk_hit;
  logic [PPN_W-1:0]  lk_ppn;
  logic [PERM_W-1:0] lk_perm;
  logic [LVL_W-1:0]  lk_level;
  logic              wr_en;
  logic [VPN_W-1:0]  wr_vpn;
  logic [ASID_W-1:0] wr_asid;
  logic              wr_glob;
  logic [PPN_W-1:0]  wr_ppn;
  logic [PERM_W-1:0] wr_perm;
  logic [LVL_W-1:0]  wr_level;
  logic              sf_en;
  logic              sf_use_addr;
  logic [VPN_W-1:0]  sf_vpn;
  logic              sf_use_asid;
  logic [ASID_W-1:0] sf_asid;

  always #5 clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn_i(lk_vpn), .lk_asid_i(lk_asid), .lk_hit_o(lk_hit),
    .lk_ppn_o(lk_ppn), .lk_perm_o(lk_perm), .lk_level_o(lk_level),
    .wr_en_i(wr_en), .wr_vpn_i(wr_vpn), .wr_asid_i(wr_asid), .wr_glob_i(wr_glob),
    .wr_ppn_i(wr_ppn), .wr_perm_i(wr_perm), .wr_level_i(wr_level),
    .sf_en_i(sf_en), .sf_use_addr_i(sf_use_addr), .sf_vpn_i(sf_vpn),
    .sf_use_asid_i(sf_use_asid), .sf_asid_i(sf_asid)
  );

  // Reference model state
  logic              m_v    [N];
  logic [VPN_W-1:0]  m_vpn  [N];
  logic [ASID_W-1:0] m_asid [N];
  logic              m_glob [N];
  logic [PPN_W-1:0]  m_ppn  [N];
  logic [PERM_W-1:0] m_perm [N];
  logic [LVL_W-1:0]  m_lvl  [N];

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  function automatic logic [VPN_W-1:0] cover_mask(input logic [LVL_W-1:0] l);
    logic [VPN_W-1:0] m;
    m = '1;
    if (l >= 2'd1) m[8:0]  = '0;
    if (l >= 2'd2) m[17:0] = '0;
    return m;
  endfunction

  function automatic logic exp_hit(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    int i;
    i = int'(v[5:0]);
    return m_v[i] && (((m_vpn[i] ^ v) & cover_mask(m_lvl[i])) == '0)
           && (m_glob[i] || m_asid[i] == a);
  endfunction

  function automatic logic [PPN_W-1:0] exp_ppn(input logic [VPN_W-1:0] v);
    int i;
    logic [PPN_W-1:0] r;
    i = int'(v[5:0]);
    r = m_ppn[i];
    if (m_lvl[i] >= 2'd1) r[8:0]  = v[8:0];
    if (m_lvl[i] >= 2'd2) r[17:0] = v[17:0];
    return r;
  endfunction

  function automatic logic fence_sel(input int i, input logic ua, input logic [VPN_W-1:0] v,
                                     input logic us, input logic [ASID_W-1:0] a);
    logic am, sm;
    am = (((m_vpn[i] ^ v) & cover_mask(m_lvl[i])) == '0);
    sm = !m_glob[i] && (m_asid[i] == a);
    return m_v[i] && (!ua || am) && (!us || sm);
  endfunction

  task automatic check_lk(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input string tag);
    logic eh;
    logic [PPN_W-1:0] ep;
    logic [PERM_W-1:0] eperm;
    logic [LVL_W-1:0] el;
    @(negedge clk);
    lk_vpn  = v;
    lk_asid = a;
    #1;
    eh    = exp_hit(v, a);
    ep    = eh ? exp_ppn(v) : '0;
    eperm = eh ? m_perm[int'(v[5:0])] : '0;
    el    = eh ? m_lvl[int'(v[5:0])] : '0;
    checks++;
    if (lk_hit !== eh || lk_ppn !== ep || lk_perm !== eperm || lk_level !== el) begin
      errors++;
      $display("FAIL %s vpn=%h asid=%h: actual hit=%b ppn=%h perm=%h lvl=%0d expected hit=%b ppn=%h perm=%h lvl=%0d",
               tag, v, a, lk_hit, lk_ppn, lk_perm, lk_level, eh, ep, eperm, el);
    end
  endtask

  // Drives one cycle of fill and/or fence, then updates the model.
  task automatic cycle_op(input logic do_wr, input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                          input logic g, input logic [PPN_W-1:0] p, input logic [PERM_W-1:0] pm,
                          input logic [LVL_W-1:0] l,
                          input logic do_sf, input logic ua, input logic [VPN_W-1:0] fv,
                          input logic us, input logic [ASID_W-1:0] fa);
    @(negedge clk);
    wr_en = do_wr; wr_vpn = v; wr_asid = a; wr_glob = g; wr_ppn = p; wr_perm = pm; wr_level = l;
    sf_en = do_sf; sf_use_addr = ua; sf_vpn = fv; sf_use_asid = us; sf_asid = fa;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    sf_en = 1'b0;
    if (do_sf) begin
      for (int i = 0; i < N; i++)
        if (fence_sel(i, ua, fv, us, fa)) m_v[i] = 1'b0;
    end else if (do_wr) begin
      int i;
      i = int'(v[5:0]);
      m_v[i] = 1'b1; m_vpn[i] = v; m_asid[i] = a; m_glob[i] = g;
      m_ppn[i] = p; m_perm[i] = pm; m_lvl[i] = l;
    end
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input logic g,
                      input logic [PPN_W-1:0] p, input logic [PERM_W-1:0] pm, input logic [LVL_W-1:0] l);
    cycle_op(1'b1, v, a, g, p, pm, l, 1'b0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic fence(input logic ua, input logic [VPN_W-1:0] fv, input logic us, input logic [ASID_W-1:0] fa);
    cycle_op(1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b1, ua, fv, us, fa);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VPN_W-1:0] va, vc, vg, vs1, vs2, vx, vy;
    void'($urandom(32'd20240607));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_vpn[i] = '0; m_asid[i] = '0; m_glob[i] = 1'b0;
      m_ppn[i] = '0; m_perm[i] = '0; m_lvl[i] = '0;
    end
    rst_n = 1'b0;
    lk_vpn = '0; lk_asid = '0;
    wr_en = 1'b0; wr_vpn = '0; wr_asid = '0; wr_glob = 1'b0; wr_ppn = '0; wr_perm = '0; wr_level = '0;
    sf_en = 1'b0; sf_use_addr = 1'b0; sf_vpn = '0; sf_use_asid = 1'b0; sf_asid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: empty after reset
    check_lk(27'h0000A5, 16'd1, "R1");
    check_lk(27'h000000, 16'd0, "R1");
    check_lk(27'h7FFFFFF, 16'hFFFF, "R1");

    // R2, R3, R5: basic fill, ASID mismatch
    va = 27'h0000A5;
    fill(va, 16'd1, 1'b0, 44'h123456, 6'b001011, 2'd0);
    check_lk(va, 16'd1, "R2");
    check_lk(va, 16'd2, "R3");
    check_lk(va ^ 27'h100, 16'd1, "R5");

    // R4: global entry
    vg = 27'h000117;
    fill(vg, 16'd5, 1'b1, 44'hFEDCBA987, 6'b110111, 2'd0);
    check_lk(vg, 16'd9, "R4");
    check_lk(vg, 16'd5, "R4");

    // R2: conflict eviction
    vc = va + 27'h40;
    fill(vc, 16'd1, 1'b0, 44'h777, 6'b000001, 2'd0);
    check_lk(va, 16'd1, "R2");
    check_lk(vc, 16'd1, "R2");

    // R6: superpages
    vs1 = (27'd5 << 9) | 27'h033;
    fill(vs1, 16'd2, 1'b0, 44'hABCFF, 6'b001111, 2'd1);
    check_lk((27'd5 << 9) | 27'h1B3, 16'd2, "R6");
    check_lk((27'd6 << 9) | 27'h033, 16'd2, "R6");
    vs2 = (27'd3 << 18) | 27'h008;
    fill(vs2, 16'd2, 1'b0, 44'h5_0000_0000, 6'b000101, 2'd2);
    check_lk((27'd3 << 18) | (27'h1F << 9) | 27'h008, 16'd2, "R6");

    // R8: address-only fence inside a superpage, also on a global slot
    fence(1'b1, (27'd5 << 9) | 27'h1B3, 1'b0, 16'd0);
    check_lk(vs1, 16'd2, "R8");
    fence(1'b1, vg, 1'b0, 16'd0);
    check_lk(vg, 16'd9, "R8");
    check_lk(vs2, 16'd2, "R8");

    // R9: ASID-only fence keeps global and other ASIDs
    fill(27'h000201, 16'd1, 1'b0, 44'h11, 6'b1, 2'd0);
    fill(27'h000202, 16'd1, 1'b1, 44'h22, 6'b1, 2'd0);
    fill(27'h000203, 16'd4, 1'b0, 44'h33, 6'b1, 2'd0);
    fence(1'b0, '0, 1'b1, 16'd1);
    check_lk(27'h000201, 16'd1, "R9");
    check_lk(27'h000202, 16'd1, "R9");
    check_lk(27'h000203, 16'd4, "R11");

    // R10: both operands
    vx = 27'h000310;
    vy = 27'h000311;
    fill(vx, 16'd2, 1'b0, 44'h44, 6'b10, 2'd0);
    fill(vy, 16'd3, 1'b1, 44'h55, 6'b10, 2'd0);
    fence(1'b1, vx, 1'b1, 16'd3);
    check_lk(vx, 16'd2, "R10");
    fence(1'b1, vy, 1'b1, 16'd3);
    check_lk(vy, 16'd7, "R10");
    fence(1'b1, vx, 1'b1, 16'd2);
    check_lk(vx, 16'd2, "R10");

    // R7, R12: full fence with a concurrent fill
    cycle_op(1'b1, 27'h000400, 16'd1, 1'b0, 44'h66, 6'b1, 2'd0, 1'b1, 1'b0, '0, 1'b0, '0);
    check_lk(27'h000400, 16'd1, "R12");
    check_lk(vs2, 16'd2, "R7");
    check_lk(27'h000203, 16'd4, "R7");

    // Random phase: R3/R11 against the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [VPN_W-1:0] rv;
      logic [ASID_W-1:0] ra;
      op = int'($urandom % 10);
      rv = VPN_W'(($urandom % 3) << 18) | VPN_W'(($urandom % 3) << 9) | VPN_W'($urandom % 8);
      ra = ASID_W'(1 + $urandom % 3);
      if (op < 3) begin
        logic [LVL_W-1:0] rl;
        rl = ($urandom % 4 == 0) ? LVL_W'($urandom % 3) : 2'd0;
        fill(rv, ra, ($urandom % 4) == 0, PPN_W'({$urandom, $urandom}), PERM_W'($urandom), rl);
      end else if (op == 3) begin
        cycle_op($urandom % 2 == 0, rv, ra, 1'b0, PPN_W'($urandom), PERM_W'($urandom), 2'd0,
                 1'b1, $urandom % 2 == 0, rv ^ VPN_W'($urandom % 2), $urandom % 2 == 0, ra);
      end else begin
        check_lk(rv, ra, "R3");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule